// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a parameterised set of sources (64 by default). For every source it keeps a pending flag, an enable bit and a 3-bit priority. Software reaches all of them through a plain 16-bit register bus with a write strobe and a combinational read port. Each cycle the block looks at every source at once. It keeps only those that are pending, enabled and have a non-zero priority, and picks the one with the highest priority. When priorities are equal, the lowest source index wins, and that index is the vector number. The block compares the winner's level against the current CPU priority level and raises a registered request to the CPU. The request carries a 7-bit vector number and a 4-bit level.

The block also owns the CPU priority level. The low three bits are software-writable. The top bit follows a trap input and cannot be written. A one-cycle acknowledge raises the level to the latched request level and pushes the old level onto a small stack. A return strobe pops it back. A global nesting-disable control makes every acknowledge lift the level straight to 7. The vector and level of the current request are also latched into a status register. That register is frozen during an acknowledge cycle.

Top module: `prio_vec_irq`

## Requirements
- R1: A pulse on source n sets its pending flag. Pending flags are at address 0x00+n/16, bit n%16. A bus write to that address stores the written bits, so writing 0 is the only way to clear a flag.
- R2: If a source pulse and a bus write that clears the same flag fall in the same cycle, the flag ends up set.
- R3: Enable bits are at address 0x08+n/16, bit n%16. A source whose enable bit is 0 still sets its flag but never wins arbitration.
- R4: Priorities are at address 0x20+n/4, bits 3*(n%4)+2 down to 3*(n%4). Priority 0 means the source never requests, and a raised request never carries level 0.
- R5: The winner has the highest priority among eligible sources. On a tie, the lowest source index wins.
- R6: irq_req is registered. It is 1 in the cycle after an eligible winner whose level is strictly greater than the 4-bit CPU level (cpu_lvl) was present, and no acknowledge was given in that cycle.
- R7: Each time a request is raised, the winner's vector and level are latched into irq_vec/irq_lvl. They can be read at 0x42 as bits 6:0 (vector) and 11:8 (level). The latch does not change in the cycle after an acknowledge.
- R8: The CPU level register at 0x41 holds a writable level in bits 2:0. Bit 3 always reads trap_active and ignores writes. While trap_active is 1, no request is raised.
- R9: On irq_ack, the level in bits 2:0 becomes the latched irq_lvl and the previous value is pushed onto the stack. irq_req is 0 in the cycle after the acknowledge.
- R10: irq_ret pops the stacked level back into bits 2:0. A return with an empty stack leaves the level unchanged. Acknowledge takes precedence over return, and return takes precedence over a software write.
- R11: The nesting-disable bit is bit 0 of the control register at 0x40. When it is 1, an acknowledge sets the level bits to 7.
- R12: After reset, all flags, enables, priorities, the level, the stack, the control register, the status latch and irq_req are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | NUM_SRC | One bit per source; a 1 sets that source's flag |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| trap_active | input | 1 | Trap level indicator; drives the top level bit |
| irq_ack | input | 1 | One-cycle acknowledge from the CPU |
| irq_ret | input | 1 | One-cycle return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 7 | Latched vector number |
| irq_lvl | output | 4 | Latched new priority level |
| cpu_lvl | output | 4 | Current CPU priority level {trap, level} |

## Verification
The bench targets tie-breaking between equal priorities. A design that scans the sources the wrong way would report the higher index. It also drives disabled sources and zero-priority sources that are pending. An arbiter that drops either qualifier would hand out their vector. A pulse arrives in the same cycle as a software clear, and a wrong precedence loses that event. The bench nests two acknowledges and then issues one return more than the stack holds, so an empty-stack pop would corrupt the level. It also raises the trap input and writes the level's read-only bit, which must mask every request. A reference model checks request, vector, level and CPU level on every cycle.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
   localparam int ADDR_W = 7;
   localparam int DATA_W = 16;
   localparam int VEC_W  = 7;
   localparam int PRI_W  = 3;
   localparam int LVL_W  = PRI_W + 1;
   localparam int BITS_PER_REG  = DATA_W;
   localparam int SLOTS_PER_REG = DATA_W / PRI_W > 4 ? 4 : DATA_W / PRI_W;

   localparam logic [ADDR_W-1:0] A_FLAG = 7'h00;
   localparam logic [ADDR_W-1:0] A_EN   = 7'h08;
   localparam logic [ADDR_W-1:0] A_PRIO = 7'h20;
   localparam logic [ADDR_W-1:0] A_CTRL = 7'h40;
   localparam logic [ADDR_W-1:0] A_LVL  = 7'h41;
   localparam logic [ADDR_W-1:0] A_STAT = 7'h42;

   typedef struct packed {
      logic             valid;
      logic [VEC_W-1:0] vec;
      logic [LVL_W-1:0] lvl;
   } win_t;
endpackage

// File: rtl/pvic_src_bank.sv
module pvic_src_bank
   import pvic_pkg::*;
#(
   parameter int NUM_SRC = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_SRC-1:0]      src_pulse,
   input  logic                    bus_we,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [NUM_SRC-1:0]      flag,
   output logic [NUM_SRC-1:0]      enab,
   output logic [NUM_SRC*PRI_W-1:0] prio,
   output logic                    rd_hit,
   output logic [DATA_W-1:0]       rd_data
);
   localparam int NREG  = NUM_SRC / BITS_PER_REG;
   localparam int NPREG = NUM_SRC / SLOTS_PER_REG;
   localparam int PBITS = SLOTS_PER_REG * PRI_W;

   logic [NUM_SRC-1:0]       flag_q, flag_d, en_q, en_d;
   logic [NUM_SRC*PRI_W-1:0] prio_q, prio_d;

   always_comb begin
      flag_d = flag_q;
      en_d   = en_q;
      prio_d = prio_q;
      for (int r = 0; r < NREG; r++) begin
         if (bus_we && bus_addr == A_FLAG + ADDR_W'(r))
            flag_d[r*BITS_PER_REG +: BITS_PER_REG] = bus_wdata;
         if (bus_we && bus_addr == A_EN + ADDR_W'(r))
            en_d[r*BITS_PER_REG +: BITS_PER_REG] = bus_wdata;
      end
      for (int r = 0; r < NPREG; r++) begin
         if (bus_we && bus_addr == A_PRIO + ADDR_W'(r))
            prio_d[r*PBITS +: PBITS] = bus_wdata[PBITS-1:0];
      end
      // hardware set dominates a same-cycle software clear
      flag_d = flag_d | src_pulse;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         en_q   <= '0;
         prio_q <= '0;
      end else begin
         flag_q <= flag_d;
         en_q   <= en_d;
         prio_q <= prio_d;
      end
   end

   always_comb begin
      rd_hit  = 1'b0;
      rd_data = '0;
      for (int r = 0; r < NREG; r++) begin
         if (bus_addr == A_FLAG + ADDR_W'(r)) begin
            rd_hit  = 1'b1;
            rd_data = flag_q[r*BITS_PER_REG +: BITS_PER_REG];
         end
         if (bus_addr == A_EN + ADDR_W'(r)) begin
            rd_hit  = 1'b1;
            rd_data = en_q[r*BITS_PER_REG +: BITS_PER_REG];
         end
      end
      for (int r = 0; r < NPREG; r++) begin
         if (bus_addr == A_PRIO + ADDR_W'(r)) begin
            rd_hit  = 1'b1;
            rd_data = {{(DATA_W-PBITS){1'b0}}, prio_q[r*PBITS +: PBITS]};
         end
      end
   end

   assign flag = flag_q;
   assign enab = en_q;
   assign prio = prio_q;
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb
   import pvic_pkg::*;
#(
   parameter int NUM_SRC = 64
) (
   input  logic [NUM_SRC-1:0]       flag,
   input  logic [NUM_SRC-1:0]       enab,
   input  logic [NUM_SRC*PRI_W-1:0] prio,
   output win_t                     win
);
   logic [NUM_SRC-1:0] elig;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
      assign elig[g] = flag[g] & enab[g] & (|prio[g*PRI_W +: PRI_W]);
   end

   // scan from the top index down; ">=" lets a lower index take equal levels
   always_comb begin
      win = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (elig[i] && (!win.valid || prio[i*PRI_W +: PRI_W] >= win.lvl[PRI_W-1:0])) begin
            win.valid = 1'b1;
            win.vec   = VEC_W'(i);
            win.lvl   = {1'b0, prio[i*PRI_W +: PRI_W]};
         end
      end
   end
endmodule

// File: rtl/pvic_lvl.sv
module pvic_lvl
   import pvic_pkg::*;
#(
   parameter int STK_DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack,
   input  logic             ret,
   input  logic             sw_we,
   input  logic [PRI_W-1:0] sw_val,
   input  logic             nest_dis,
   input  logic [PRI_W-1:0] new_lvl,
   output logic [PRI_W-1:0] ipl
);
   localparam int PTR_W = $clog2(STK_DEPTH + 1);
   localparam int IDX_W = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1;
   localparam logic [PRI_W-1:0] TOP_LVL = '1;

   logic [PRI_W-1:0] stk [STK_DEPTH];
   logic [PTR_W-1:0] ptr;
   logic [PRI_W-1:0] ipl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ipl_q <= '0;
         ptr   <= '0;
         for (int i = 0; i < STK_DEPTH; i++) stk[i] <= '0;
      end else if (ack) begin
         if (ptr < PTR_W'(STK_DEPTH)) begin
            stk[IDX_W'(ptr)] <= ipl_q;
            ptr <= ptr + 1'b1;
         end
         ipl_q <= nest_dis ? TOP_LVL : new_lvl;
      end else if (ret) begin
         if (ptr != '0) begin
            ipl_q <= stk[IDX_W'(ptr - 1'b1)];
            ptr   <= ptr - 1'b1;
         end
      end else if (sw_we) begin
         ipl_q <= sw_val;
      end
   end

   assign ipl = ipl_q;
endmodule

// File: rtl/prio_vec_irq.sv
module prio_vec_irq
   import pvic_pkg::*;
#(
   parameter int NUM_SRC   = 64,
   parameter int STK_DEPTH = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_pulse,
   input  logic               bus_we,
   input  logic [6:0]         bus_addr,
   input  logic [15:0]        bus_wdata,
   output logic [15:0]        bus_rdata,
   input  logic               trap_active,
   input  logic               irq_ack,
   input  logic               irq_ret,
   output logic               irq_req,
   output logic [6:0]         irq_vec,
   output logic [3:0]         irq_lvl,
   output logic [3:0]         cpu_lvl
);
   if (NUM_SRC % BITS_PER_REG != 0 || NUM_SRC < BITS_PER_REG || NUM_SRC > (1 << VEC_W))
      $error("NUM_SRC must be a multiple of 16 between 16 and 128");
   if (STK_DEPTH < 1)
      $error("STK_DEPTH must be at least 1");
   if (ADDR_W != 7 || DATA_W != 16 || LVL_W != 4)
      $error("package widths do not match the port list");

   logic [NUM_SRC-1:0]       flag, enab;
   logic [NUM_SRC*PRI_W-1:0] prio;
   logic                     bank_hit;
   logic [DATA_W-1:0]        bank_rdata;
   win_t                     win;
   logic [PRI_W-1:0]         ipl;
   logic                     nest_q;
   logic                     req_q;
   logic [VEC_W-1:0]         vec_q;
   logic [LVL_W-1:0]         lvl_q;
   logic                     raise;

   pvic_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .flag(flag), .enab(enab), .prio(prio),
      .rd_hit(bank_hit), .rd_data(bank_rdata)
   );

   pvic_arb #(.NUM_SRC(NUM_SRC)) u_arb (
      .flag(flag), .enab(enab), .prio(prio), .win(win)
   );

   pvic_lvl #(.STK_DEPTH(STK_DEPTH)) u_lvl (
      .clk(clk), .rst_n(rst_n), .ack(irq_ack), .ret(irq_ret),
      .sw_we(bus_we && bus_addr == A_LVL), .sw_val(bus_wdata[PRI_W-1:0]),
      .nest_dis(nest_q), .new_lvl(lvl_q[PRI_W-1:0]), .ipl(ipl)
   );

   assign cpu_lvl = {trap_active, ipl};
   assign raise   = win.valid && (win.lvl > cpu_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nest_q <= 1'b0;
         req_q  <= 1'b0;
         vec_q  <= '0;
         lvl_q  <= '0;
      end else begin
         if (bus_we && bus_addr == A_CTRL) nest_q <= bus_wdata[0];
         req_q <= raise && !irq_ack;
         if (raise && !irq_ack) begin
            vec_q <= win.vec;
            lvl_q <= win.lvl;
         end
      end
   end

   always_comb begin
      unique case (bus_addr)
         A_CTRL:  bus_rdata = {{(DATA_W-1){1'b0}}, nest_q};
         A_LVL:   bus_rdata = {{(DATA_W-LVL_W){1'b0}}, cpu_lvl};
         A_STAT:  bus_rdata = {4'b0, lvl_q, 1'b0, vec_q};
         default: bus_rdata = bank_hit ? bank_rdata : '0;
      endcase
   end

   assign irq_req = req_q;
   assign irq_vec = vec_q;
   assign irq_lvl = lvl_q;
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       irq_req,
   input logic [6:0] irq_vec,
   input logic [3:0] irq_lvl,
   input logic       irq_ack,
   input logic [3:0] cpu_lvl,
   input logic       trap_active,
   input logic       nest_dis
);
   p_req_above_cpu_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_lvl > $past(cpu_lvl));

   p_level_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_lvl != 4'd0);

   p_status_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> ($stable(irq_vec) && $stable(irq_lvl)));

   p_req_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_req);

   p_ack_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> cpu_lvl[2:0] == ($past(nest_dis) ? 3'd7 : $past(irq_lvl[2:0])));

   p_trap_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(trap_active) |-> !irq_req);
endmodule

bind prio_vec_irq pvic_chk u_chk (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
   .irq_lvl(irq_lvl), .irq_ack(irq_ack), .cpu_lvl(cpu_lvl),
   .trap_active(trap_active), .nest_dis(nest_q)
);

// File: tb/prio_vec_irq_tb.sv
module prio_vec_irq_tb;
   localparam int N = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] src_pulse = '0;
   logic         bus_we = 1'b0;
   logic [6:0]   bus_addr = '0;
   logic [15:0]  bus_wdata = '0;
   logic [15:0]  bus_rdata;
   logic         trap_active = 1'b0;
   logic         irq_ack = 1'b0;
   logic         irq_ret = 1'b0;
   logic         irq_req;
   logic [6:0]   irq_vec;
   logic [3:0]   irq_lvl;
   logic [3:0]   cpu_lvl;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   prio_vec_irq u_dut (
      .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .trap_active(trap_active), .irq_ack(irq_ack), .irq_ret(irq_ret),
      .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl), .cpu_lvl(cpu_lvl)
   );

   // behavioural reference model
   bit m_flag [N];
   bit m_en   [N];
   int m_pri  [N];
   int m_ipl;
   int m_stk [$];
   bit m_nest;
   bit m_req;
   int m_vec, m_lvl;

   always @(posedge clk) begin : model
      int  wv, wl, cur;
      bit  found, cond;
      if (!rst_n) begin
         for (int n = 0; n < N; n++) begin m_flag[n] = 0; m_en[n] = 0; m_pri[n] = 0; end
         m_ipl = 0; m_stk.delete(); m_nest = 0; m_req = 0; m_vec = 0; m_lvl = 0;
      end else begin
         found = 0; wv = 0; wl = 0;
         for (int n = 0; n < N; n++)
            if (m_flag[n] && m_en[n] && m_pri[n] != 0 && (!found || m_pri[n] > wl)) begin
               found = 1; wv = n; wl = m_pri[n];
            end
         cur  = (trap_active ? 8 : 0) + m_ipl;
         cond = found && wl > cur;
         if (irq_ack) begin
            if (m_stk.size() < 8) m_stk.push_back(m_ipl);
            m_ipl = m_nest ? 7 : m_lvl;
         end else if (irq_ret) begin
            if (m_stk.size() > 0) m_ipl = m_stk.pop_back();
         end else if (bus_we && bus_addr == 7'h41) begin
            m_ipl = bus_wdata & 7;
         end
         if (cond && !irq_ack) begin m_vec = wv; m_lvl = wl; end
         m_req = cond && !irq_ack;
         if (bus_we && bus_addr == 7'h40) m_nest = bus_wdata[0];
         for (int n = 0; n < N; n++) begin
            if (bus_we && bus_addr == 7'(n / 16))     m_flag[n] = bus_wdata[n % 16];
            if (bus_we && bus_addr == 7'(8 + n / 16)) m_en[n]   = bus_wdata[n % 16];
            if (bus_we && bus_addr == 7'(32 + n / 4)) m_pri[n]  = (bus_wdata >> (3 * (n % 4))) & 7;
            if (src_pulse[n]) m_flag[n] = 1;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic compare_model();
      check(irq_req == m_req, "R6 irq_req vs model", irq_req, m_req);
      check(irq_vec == 7'(m_vec) && irq_lvl == 4'(m_lvl), "R7 vec/lvl vs model",
            {irq_lvl, 1'b0, irq_vec}, (m_lvl << 8) | m_vec);
      check(cpu_lvl == {trap_active, 3'(m_ipl)}, "R9 cpu_lvl vs model",
            cpu_lvl, (trap_active ? 8 : 0) + m_ipl);
   endtask

   task automatic step(input int k = 1);
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         if (rst_n) compare_model();
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [15:0] d);
      bus_we = 1; bus_addr = a; bus_wdata = d;
      step();
      bus_we = 0;
   endtask

   task automatic pulse(input int n);
      src_pulse[n] = 1'b1;
      step();
      src_pulse = '0;
   endtask

   task automatic ack();
      irq_ack = 1; step(); irq_ack = 0;
   endtask

   task automatic ret();
      irq_ret = 1; step(); irq_ret = 0;
   endtask

   task automatic rd(input logic [6:0] a, input logic [15:0] exp, input string tag);
      bus_addr = a;
      #1;
      check(bus_rdata == exp, tag, bus_rdata, exp);
   endtask

   task automatic out(input bit req, input int vec, input int lvl, input string tag);
      check(irq_req == req && (!req || (irq_vec == 7'(vec) && irq_lvl == 4'(lvl))), tag,
            {irq_req, irq_lvl, 1'b0, irq_vec}, (int'(req) << 12) | (lvl << 8) | vec);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 50000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1;
      step();
      // R12 reset state
      out(0, 0, 0, "R12 no request after reset");
      check(cpu_lvl == 4'd0, "R12 cpu level after reset", cpu_lvl, 0);
      rd(7'h41, 16'h0000, "R12 level reg after reset");
      rd(7'h42, 16'h0000, "R12 status after reset");
      rd(7'h00, 16'h0000, "R12 flags after reset");

      // source 5 at priority 3
      wr(7'h21, 16'h0018);
      wr(7'h08, 16'h0020);
      pulse(5);
      step(2);
      out(1, 5, 3, "R6 request for source 5");
      rd(7'h00, 16'h0020, "R1 flag bit 5 set");
      rd(7'h42, 16'h0305, "R7 status register contents");

      // source 20 at same priority: lower index keeps winning
      wr(7'h25, 16'h0003);
      wr(7'h09, 16'h0010);
      pulse(20);
      step(2);
      out(1, 5, 3, "R5 tie goes to lower vector");

      // source 40 at priority 6
      wr(7'h2A, 16'h0006);
      wr(7'h0A, 16'h0100);
      pulse(40);
      step(2);
      out(1, 40, 6, "R5 higher priority wins");

      // source 41 priority 7 but disabled
      wr(7'h2A, 16'h003E);
      pulse(41);
      step(2);
      out(1, 40, 6, "R3 disabled source ignored");
      rd(7'h02, 16'h0300, "R3 disabled source flag still sets");

      // source 42 enabled with priority 0
      wr(7'h0A, 16'h0500);
      pulse(42);
      step(2);
      out(1, 40, 6, "R4 zero priority source ignored");

      // acknowledge
      ack();
      check(cpu_lvl == 4'd6, "R9 level raised on ack", cpu_lvl, 6);
      check(irq_req == 1'b0, "R9 request drops after ack", irq_req, 0);
      step(2);
      out(0, 0, 0, "R6 no request at equal level");

      // nest: enable 41 (priority 7)
      wr(7'h0A, 16'h0700);
      step(2);
      out(1, 41, 7, "R6 higher level preempts");
      ack();
      check(cpu_lvl == 4'd7, "R9 nested ack level", cpu_lvl, 7);
      ret();
      check(cpu_lvl == 4'd6, "R10 first pop", cpu_lvl, 6);
      ret();
      check(cpu_lvl == 4'd0, "R10 second pop", cpu_lvl, 0);
      ret();
      check(cpu_lvl == 4'd0, "R10 pop on empty stack", cpu_lvl, 0);
      step(2);
      out(1, 41, 7, "R6 request returns after pops");

      // software clear of 40 and 41
      wr(7'h02, 16'h0400);
      step(2);
      out(1, 5, 3, "R1 cleared flags no longer win");
      rd(7'h02, 16'h0400, "R1 flag register after clear");

      // pulse and clear in the same cycle
      src_pulse[40] = 1'b1;
      wr(7'h02, 16'h0000);
      src_pulse = '0;
      rd(7'h02, 16'h0100, "R2 hardware set beats clear");
      step(2);
      out(1, 40, 6, "R2 surviving flag requests");

      // level register and trap bit
      wr(7'h41, 16'h000F);
      rd(7'h41, 16'h0007, "R8 top bit not writable");
      step(2);
      out(0, 0, 0, "R8 level 7 masks all");
      trap_active = 1;
      wr(7'h41, 16'h0000);
      rd(7'h41, 16'h0008, "R8 trap bit reads back");
      step(3);
      out(0, 0, 0, "R8 trap masks requests");
      trap_active = 0;
      step(2);
      out(1, 40, 6, "R8 request after trap clears");

      // nesting disable
      wr(7'h40, 16'h0001);
      rd(7'h40, 16'h0001, "R11 control bit reads back");
      step(1);
      ack();
      check(cpu_lvl == 4'd7, "R11 nesting disable forces level 7", cpu_lvl, 7);
      ret();
      check(cpu_lvl == 4'd0, "R10 pop after forced level", cpu_lvl, 0);
      step(4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule